// File: doc/BRIEF.md
# Pointer-Scalar Instruction Validator

This block screens a 64-byte two-operation tensor-scalar instruction descriptor and decides whether it is a legal pointer-scalar operation. In this form, both scalar operands are fetched from memory. The descriptor therefore has to name each scalar by an address and may not carry it inline. The block reads the fields it needs at fixed byte offsets and evaluates every rule in parallel. One clock after a descriptor is strobed in, it presents a single pass/fail verdict together with a bitmap that marks every rule the descriptor broke.

An issue stage uses it to reject a malformed descriptor before the descriptor reaches a vector engine. The block does not execute the operation. Multi-byte fields are little-endian (byte k of the descriptor is `desc_i[8k+7:8k]`). A pointer's channel index is its address shifted right by `CH_SHIFT`. The byte offsets decoded are: operation code 0, accumulator command 12, reserved 13–15, input dtype 32, output dtype 33, channel count 34, first source selector 35, first op 36, second op 37, operand-order code 38, second source selector 39, first pointer 40–43, second pointer 44–47.

Top module: `ptr_scalar_validator`

## Requirements
- R1: `verdict_vld_o` rises exactly one cycle after a cycle with `desc_vld_i` high. In any cycle after one with `desc_vld_i` low, `verdict_vld_o`, `legal_o` and `fail_o` are all zero. When `verdict_vld_o` is high, `legal_o` is high exactly when `fail_o` is zero.
- R2: Only operation code 0x44 (arithmetic class) and 0x54 (bitvector class) are accepted; any other code sets fail bit 0. The bitvector rules apply only to 0x54, and every other code is judged under the arithmetic rules.
- R3: A nonzero value in either source selector byte (35 or 39) sets fail bit 1.
- R4: A nonzero accumulator command (byte 12), or any nonzero reserved byte 13–15, sets fail bit 2.
- R5: A channel count (byte 34) of 0 or above `MAX_CH` (128) sets fail bit 3.
- R6: A pointer whose channel index is not below the channel count sets fail bit 4 (first pointer) or fail bit 5 (second pointer).
- R7: Under the arithmetic class, a pointer that is not 4-byte aligned sets fail bit 6 (first) or 7 (second). Under the bitvector class, the required alignment is the input dtype size: codes 0–1 take 1 byte, codes 2–5 take 2 bytes, and all other codes take 4 bytes.
- R8: Under the arithmetic class, an op code of 0x20 or above, or divide 0x07, pow 0x1A or mod 0x1B, in either op field sets fail bit 8. Under the bitvector class, each op must be bypass 0x00 or one of 0x20–0x28 (not, four shifts, and, or, xor, crc32), otherwise fail bit 8 is set.
- R9: A first op equal to bypass (0x00) paired with a second op that is not bypass sets fail bit 9.
- R10: Under the arithmetic class, an input dtype above 8 or an output dtype above 9 sets fail bit 10. Code 9 is the rounded-fp32 type, which is allowed only on output. Under the bitvector class, fail bit 10 is set unless the input and output dtypes are equal and are one of 0, 2, 7 or 8.
- R11: An operand-order code (byte 38) above 3 sets fail bit 11.
- R12: Every violated rule is reported in the same verdict, and the bits of `fail_o` are independent of one another. Descriptor bytes outside the decoded offsets have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_vld_i | input | 1 | Descriptor strobe |
| desc_i | input | 512 | Instruction descriptor, byte k at bits 8k+7:8k |
| verdict_vld_o | output | 1 | Verdict present this cycle |
| legal_o | output | 1 | Descriptor passed every rule |
| fail_o | output | 12 | One bit per violated rule |

## Verification
The bench sweeps every operation code, the whole grid of input and output dtype pairs under both classes, and every channel count from 0 to past the limit. It also covers both op fields over the low op range, pointer channel indices straddling the count, and all four low address offsets against each bitvector dtype size. A design that skipped divide, pow or mod would pass an illegal arithmetic op. A design using a fixed 4-byte alignment for bitvector data would reject legal byte pointers. An off-by-one range compare would accept a pointer to the first channel beyond the active set. A priority encoder in place of the bitmap shows up in the stacked-fault descriptor, where a first-error-only design reports one bit instead of the full set. Filler bytes outside the decoded offsets stay nonzero throughout, so a design that decoded a wrong offset fails the checks on the base legal descriptor.

// File: rtl/ptrval_pkg.sv
package ptrval_pkg;

  localparam int unsigned FAIL_W = 12;

  localparam int unsigned F_OPCODE   = 0;
  localparam int unsigned F_SRC      = 1;
  localparam int unsigned F_ACC_RSV  = 2;
  localparam int unsigned F_NCH      = 3;
  localparam int unsigned F_P0_RANGE = 4;
  localparam int unsigned F_P1_RANGE = 5;
  localparam int unsigned F_P0_ALIGN = 6;
  localparam int unsigned F_P1_ALIGN = 7;
  localparam int unsigned F_OPSET    = 8;
  localparam int unsigned F_COMPOSE  = 9;
  localparam int unsigned F_DTYPE    = 10;
  localparam int unsigned F_REVERSE  = 11;

  localparam logic [7:0] OPC_ARITH  = 8'h44;
  localparam logic [7:0] OPC_BITVEC = 8'h54;

  localparam logic [7:0] OP_BYPASS   = 8'h00;
  localparam logic [7:0] OP_DIVIDE   = 8'h07;
  localparam logic [7:0] OP_POW      = 8'h1A;
  localparam logic [7:0] OP_MOD      = 8'h1B;
  localparam logic [7:0] OP_ARITH_LIM = 8'h20;
  localparam logic [7:0] OP_BV_FIRST = 8'h20;
  localparam logic [7:0] OP_BV_LAST  = 8'h28;

  localparam logic [7:0] DT_U8  = 8'd0;
  localparam logic [7:0] DT_U16 = 8'd2;
  localparam logic [7:0] DT_U32 = 8'd7;
  localparam logic [7:0] DT_I32 = 8'd8;
  localparam logic [7:0] DT_IN_MAX  = 8'd8;
  localparam logic [7:0] DT_OUT_MAX = 8'd9;
  localparam logic [7:0] REV_MAX    = 8'd3;

  // byte offsets whose meaning other stages depend on
  localparam int unsigned B_OPCODE = 0;
  localparam int unsigned B_ACC    = 12;
  localparam int unsigned B_RSV    = 13;
  localparam int unsigned B_IN_DT  = 32;
  localparam int unsigned B_OUT_DT = 33;
  localparam int unsigned B_NCH    = 34;
  localparam int unsigned B_SRC0   = 35;
  localparam int unsigned B_OP0    = 36;
  localparam int unsigned B_OP1    = 37;
  localparam int unsigned B_REV    = 38;
  localparam int unsigned B_SRC1   = 39;
  localparam int unsigned B_PTR0   = 40;
  localparam int unsigned B_PTR1   = 44;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [7:0]  acc_cmd;
    logic [23:0] rsv;
    logic [7:0]  in_dt;
    logic [7:0]  out_dt;
    logic [7:0]  n_ch;
    logic [7:0]  src0;
    logic [7:0]  op0;
    logic [7:0]  op1;
    logic [7:0]  rev;
    logic [7:0]  src1;
    logic [31:0] ptr0;
    logic [31:0] ptr1;
  } fields_t;

  typedef enum logic [1:0] {ALIGN_1 = 2'd0, ALIGN_2 = 2'd1, ALIGN_4 = 2'd2} align_e;

  function automatic align_e dt_align(input logic [7:0] dt);
    if (dt <= 8'd1)      return ALIGN_1;
    else if (dt <= 8'd5) return ALIGN_2;
    else                 return ALIGN_4;
  endfunction

  function automatic logic arith_op_ok(input logic [7:0] op);
    return (op < OP_ARITH_LIM) && (op != OP_DIVIDE) && (op != OP_POW) && (op != OP_MOD);
  endfunction

  function automatic logic bitvec_op_ok(input logic [7:0] op);
    return (op == OP_BYPASS) || ((op >= OP_BV_FIRST) && (op <= OP_BV_LAST));
  endfunction

  function automatic logic bitvec_dt_ok(input logic [7:0] dt);
    return (dt == DT_U8) || (dt == DT_U16) || (dt == DT_U32) || (dt == DT_I32);
  endfunction

endpackage

// File: rtl/ptrval_decode.sv
module ptrval_decode
  import ptrval_pkg::*;
#(
  parameter int unsigned DESC_BYTES = 64,
  localparam int unsigned DESC_W = DESC_BYTES * 8
) (
  input  logic [DESC_W-1:0] desc_i,
  output fields_t           fld_o
);

  function automatic logic [7:0] byte_at(input logic [DESC_W-1:0] d, input int unsigned k);
    return d[8*k +: 8];
  endfunction

  function automatic logic [31:0] word_at(input logic [DESC_W-1:0] d, input int unsigned k);
    return {d[8*(k+3) +: 8], d[8*(k+2) +: 8], d[8*(k+1) +: 8], d[8*k +: 8]};
  endfunction

  always_comb begin
    fld_o.opcode  = byte_at(desc_i, B_OPCODE);
    fld_o.acc_cmd = byte_at(desc_i, B_ACC);
    fld_o.rsv     = {byte_at(desc_i, B_RSV + 2), byte_at(desc_i, B_RSV + 1), byte_at(desc_i, B_RSV)};
    fld_o.in_dt   = byte_at(desc_i, B_IN_DT);
    fld_o.out_dt  = byte_at(desc_i, B_OUT_DT);
    fld_o.n_ch    = byte_at(desc_i, B_NCH);
    fld_o.src0    = byte_at(desc_i, B_SRC0);
    fld_o.op0     = byte_at(desc_i, B_OP0);
    fld_o.op1     = byte_at(desc_i, B_OP1);
    fld_o.rev     = byte_at(desc_i, B_REV);
    fld_o.src1    = byte_at(desc_i, B_SRC1);
    fld_o.ptr0    = word_at(desc_i, B_PTR0);
    fld_o.ptr1    = word_at(desc_i, B_PTR1);
  end

endmodule

// File: rtl/ptrval_ptr_chk.sv
module ptrval_ptr_chk
  import ptrval_pkg::*;
#(
  parameter int unsigned PTR_W    = 32,
  parameter int unsigned CH_SHIFT = 16
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       n_ch_i,
  input  logic             is_bitvec_i,
  input  logic [7:0]       in_dt_i,
  output logic             range_fail_o,
  output logic             align_fail_o
);

  logic [PTR_W-1:0] chan;
  align_e           need;

  generate
    if (CH_SHIFT >= PTR_W) begin : g_one_chan
      assign chan = '0;
    end else begin : g_shift
      assign chan = ptr_i >> CH_SHIFT;
    end
  endgenerate

  assign range_fail_o = chan >= PTR_W'(n_ch_i);

  always_comb begin
    need = is_bitvec_i ? dt_align(in_dt_i) : ALIGN_4;
    unique case (need)
      ALIGN_1: align_fail_o = 1'b0;
      ALIGN_2: align_fail_o = ptr_i[0];
      default: align_fail_o = |ptr_i[1:0];
    endcase
  end

  // a pointer at address 0 sits in channel 0 and is aligned for any class
  AST_ZERO_PTR_OK: assert final (!(ptr_i == '0 && n_ch_i != 8'd0) || (!range_fail_o && !align_fail_o)); // R7

endmodule

// File: rtl/ptrval_rules.sv
module ptrval_rules
  import ptrval_pkg::*;
#(
  parameter int unsigned MAX_CH = 128
) (
  input  fields_t           fld_i,
  output logic              is_bitvec_o,
  output logic [FAIL_W-1:0] fail_o
);

  logic ops_ok, dt_ok;

  assign is_bitvec_o = fld_i.opcode == OPC_BITVEC;

  always_comb begin
    if (is_bitvec_o) begin
      ops_ok = bitvec_op_ok(fld_i.op0) && bitvec_op_ok(fld_i.op1);
      dt_ok  = (fld_i.in_dt == fld_i.out_dt) && bitvec_dt_ok(fld_i.in_dt);
    end else begin
      ops_ok = arith_op_ok(fld_i.op0) && arith_op_ok(fld_i.op1);
      dt_ok  = (fld_i.in_dt <= DT_IN_MAX) && (fld_i.out_dt <= DT_OUT_MAX);
    end
  end

  always_comb begin
    fail_o            = '0;
    fail_o[F_OPCODE]  = (fld_i.opcode != OPC_ARITH) && (fld_i.opcode != OPC_BITVEC);
    fail_o[F_SRC]     = (|fld_i.src0) || (|fld_i.src1);
    fail_o[F_ACC_RSV] = (|fld_i.acc_cmd) || (|fld_i.rsv);
    fail_o[F_NCH]     = (fld_i.n_ch == 8'd0) || (int'(fld_i.n_ch) > int'(MAX_CH));
    fail_o[F_OPSET]   = !ops_ok;
    fail_o[F_COMPOSE] = (fld_i.op0 == OP_BYPASS) && (fld_i.op1 != OP_BYPASS);
    fail_o[F_DTYPE]   = !dt_ok;
    fail_o[F_REVERSE] = fld_i.rev > REV_MAX;
  end

  // the pointer bits are owned by the pointer checkers
  AST_RULES_NO_PTR_BITS: assert final (fail_o[F_P1_ALIGN:F_P0_RANGE] == 4'b0); // R12

endmodule

// File: rtl/ptr_scalar_validator.sv
module ptr_scalar_validator
  import ptrval_pkg::*;
#(
  parameter int unsigned DESC_BYTES = 64,
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned CH_SHIFT   = 16,
  parameter int unsigned MAX_CH     = 128,
  localparam int unsigned DESC_W    = DESC_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_vld_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic              verdict_vld_o,
  output logic              legal_o,
  output logic [FAIL_W-1:0] fail_o
);

  fields_t           fld;
  logic              is_bitvec;
  logic [FAIL_W-1:0] rule_fail;
  logic [FAIL_W-1:0] fail_d;
  logic [PTR_W-1:0]  ptrs [2];
  logic [1:0]        rng_fail, aln_fail;

  ptrval_decode #(.DESC_BYTES(DESC_BYTES)) u_decode (
    .desc_i (desc_i),
    .fld_o  (fld)
  );

  ptrval_rules #(.MAX_CH(MAX_CH)) u_rules (
    .fld_i       (fld),
    .is_bitvec_o (is_bitvec),
    .fail_o      (rule_fail)
  );

  assign ptrs[0] = PTR_W'(fld.ptr0);
  assign ptrs[1] = PTR_W'(fld.ptr1);

  generate
    for (genvar p = 0; p < 2; p++) begin : g_ptr
      ptrval_ptr_chk #(.PTR_W(PTR_W), .CH_SHIFT(CH_SHIFT)) u_chk (
        .ptr_i        (ptrs[p]),
        .n_ch_i       (fld.n_ch),
        .is_bitvec_i  (is_bitvec),
        .in_dt_i      (fld.in_dt),
        .range_fail_o (rng_fail[p]),
        .align_fail_o (aln_fail[p])
      );
    end
  endgenerate

  always_comb begin
    fail_d             = rule_fail;
    fail_d[F_P0_RANGE] = rng_fail[0];
    fail_d[F_P1_RANGE] = rng_fail[1];
    fail_d[F_P0_ALIGN] = aln_fail[0];
    fail_d[F_P1_ALIGN] = aln_fail[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_vld_o <= 1'b0;
      legal_o       <= 1'b0;
      fail_o        <= '0;
    end else if (desc_vld_i) begin
      verdict_vld_o <= 1'b1;
      legal_o       <= ~|fail_d;
      fail_o        <= fail_d;
    end else begin
      verdict_vld_o <= 1'b0;
      legal_o       <= 1'b0;
      fail_o        <= '0;
    end
  end

  AST_VERDICT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_vld_i |=> verdict_vld_o); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_vld_i |=> (!verdict_vld_o && !legal_o && fail_o == '0)); // R1
  AST_LEGAL_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_vld_o && legal_o) |-> ($past(desc_i[7:0]) == OPC_ARITH || $past(desc_i[7:0]) == OPC_BITVEC)); // R2
  AST_LEGAL_SRC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_vld_o && legal_o) |-> ($past(desc_i[8*B_SRC0 +: 8]) == 8'd0 && $past(desc_i[8*B_SRC1 +: 8]) == 8'd0)); // R3
  AST_LEGAL_NCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_vld_o && legal_o) |-> ($past(desc_i[8*B_NCH +: 8]) != 8'd0 && int'($past(desc_i[8*B_NCH +: 8])) <= int'(MAX_CH))); // R5

endmodule

// File: tb/ptr_scalar_validator_bench.sv
module ptr_scalar_validator_bench;

  localparam int unsigned DESC_BYTES = 64;
  localparam int unsigned DW = DESC_BYTES * 8;
  localparam int unsigned CH_SHIFT = 16;
  localparam int unsigned MAX_CH = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dvld = 1'b0;
  logic [DW-1:0] desc = '0;
  logic          vld_o, legal;
  logic [11:0]   fail;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptr_scalar_validator #(.DESC_BYTES(DESC_BYTES), .PTR_W(32), .CH_SHIFT(CH_SHIFT), .MAX_CH(MAX_CH)) u_ptr_scalar_validator (
    .clk_i(clk), .rst_ni(rst_n), .desc_vld_i(dvld), .desc_i(desc),
    .verdict_vld_o(vld_o), .legal_o(legal), .fail_o(fail)
  );

  function automatic logic [7:0] gb(input logic [DW-1:0] d, input int k);
    return d[8*k +: 8];
  endfunction

  function automatic void sb(ref logic [DW-1:0] d, input int k, input logic [7:0] v);
    d[8*k +: 8] = v;
  endfunction

  function automatic void sw(ref logic [DW-1:0] d, input int k, input logic [31:0] v);
    for (int i = 0; i < 4; i++) d[8*(k+i) +: 8] = v[8*i +: 8];
  endfunction

  function automatic logic [31:0] gw(input logic [DW-1:0] d, input int k);
    return {d[8*(k+3) +: 8], d[8*(k+2) +: 8], d[8*(k+1) +: 8], d[8*k +: 8]};
  endfunction

  // expected bitmap straight from the requirement list
  function automatic logic [11:0] model(input logic [DW-1:0] d);
    logic [11:0] e;
    logic bv;
    logic [7:0] o0, o1, ind, outd, nch;
    int sz;
    e = '0;
    bv = gb(d, 0) == 8'h54;
    o0 = gb(d, 36); o1 = gb(d, 37); ind = gb(d, 32); outd = gb(d, 33); nch = gb(d, 34);
    e[0] = !(gb(d, 0) == 8'h44 || bv);
    e[1] = gb(d, 35) != 0 || gb(d, 39) != 0;
    e[2] = gb(d, 12) != 0 || gb(d, 13) != 0 || gb(d, 14) != 0 || gb(d, 15) != 0;
    e[3] = nch == 0 || int'(nch) > MAX_CH;
    e[4] = (gw(d, 40) >> CH_SHIFT) >= 32'(nch);
    e[5] = (gw(d, 44) >> CH_SHIFT) >= 32'(nch);
    sz = !bv ? 4 : (ind <= 1) ? 1 : (ind <= 5) ? 2 : 4;
    e[6] = (gw(d, 40) % sz) != 0;
    e[7] = (gw(d, 44) % sz) != 0;
    if (bv) begin
      e[8]  = !((o0 == 0 || (o0 >= 8'h20 && o0 <= 8'h28)) && (o1 == 0 || (o1 >= 8'h20 && o1 <= 8'h28)));
      e[10] = !(ind == outd && (ind == 0 || ind == 2 || ind == 7 || ind == 8));
    end else begin
      e[8]  = !(o0 < 8'h20 && o0 != 8'h07 && o0 != 8'h1A && o0 != 8'h1B &&
                o1 < 8'h20 && o1 != 8'h07 && o1 != 8'h1A && o1 != 8'h1B);
      e[10] = !(ind <= 8 && outd <= 9);
    end
    e[9]  = o0 == 0 && o1 != 0;
    e[11] = gb(d, 38) > 3;
    return e;
  endfunction

  function automatic logic [DW-1:0] base(input bit bitvec);
    logic [DW-1:0] d;
    for (int k = 0; k < DESC_BYTES; k++) d[8*k +: 8] = 8'hA5;  // filler outside decoded fields
    sb(d, 0, bitvec ? 8'h54 : 8'h44);
    sb(d, 12, 0); sb(d, 13, 0); sb(d, 14, 0); sb(d, 15, 0);
    sb(d, 32, bitvec ? 8'd7 : 8'd6); sb(d, 33, bitvec ? 8'd7 : 8'd6);
    sb(d, 34, 8'd8); sb(d, 35, 0); sb(d, 39, 0);
    sb(d, 36, bitvec ? 8'h25 : 8'h01); sb(d, 37, 8'h00); sb(d, 38, 8'd1);
    sw(d, 40, 32'h0000_0010);
    sw(d, 44, 32'h0003_0004);
    return d;
  endfunction

  task automatic run(input logic [DW-1:0] d, input string req);
    logic [11:0] e;
    e = model(d);
    @(negedge clk);
    desc = d; dvld = 1'b1;
    @(negedge clk);
    dvld = 1'b0;
    checks++;
    if (vld_o !== 1'b1 || fail !== e || legal !== (e == 0)) begin
      errors++;
      $display("FAIL %s: vld=%0b legal=%0b fail=%03h, expected vld=1 legal=%0b fail=%03h",
               req, vld_o, legal, fail, e == 0, e);
    end
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    checks++;
    if (vld_o !== 1'b0 || legal !== 1'b0 || fail !== 12'h000) begin
      errors++;
      $display("FAIL %s: idle vld=%0b legal=%0b fail=%03h, expected 0 0 000", req, vld_o, legal, fail);
    end
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    checks++;
    if (vld_o !== 1'b0 || legal !== 1'b0 || fail !== 12'h000) begin
      errors++;
      $display("FAIL R1 reset: vld=%0b legal=%0b fail=%03h, expected 0 0 000", vld_o, legal, fail);
    end
    rst_n = 1'b1;

    // R1 / R12: base legal descriptors of both classes, then idle clears
    run(base(0), "R1 arith base legal");
    check_idle("R1 after arith verdict");
    run(base(1), "R12 bitvec base legal");
    check_idle("R1 after bitvec verdict");

    // R2: every operation code
    for (int c = 0; c < 256; c++) begin
      d = base(0); sb(d, 0, 8'(c)); run(d, "R2 opcode sweep");
    end

    // R3: source selectors
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        d = base(0); sb(d, 35, 8'(a)); sb(d, 39, 8'(b)); run(d, "R3 source selectors");
      end

    // R4: accumulator and reserved bytes
    foreach (d[i]) ;
    for (int k = 12; k < 16; k++)
      for (int v = 0; v < 3; v++) begin
        d = base(v[0]); sb(d, k, (v == 0) ? 8'h01 : 8'h80); run(d, "R4 acc/reserved");
      end

    // R5: channel count, pointers in channel 0
    for (int n = 0; n < 256; n += (n < 132) ? 1 : 41) begin
      d = base(0); sb(d, 34, 8'(n)); sw(d, 40, 32'h0); sw(d, 44, 32'h0); run(d, "R5 channel count");
    end

    // R6: pointer channel index around the count
    for (int n = 1; n < 12; n += 3)
      for (int ch = 0; ch < 14; ch++) begin
        d = base(0); sb(d, 34, 8'(n));
        sw(d, 40, 32'(ch) << CH_SHIFT); sw(d, 44, (32'(13 - ch) << CH_SHIFT) | 32'h8);
        run(d, "R6 pointer range");
      end

    // R7: alignment under both classes and every dtype
    for (int off = 0; off < 4; off++) begin
      d = base(0); sw(d, 40, 32'h100 + 32'(off)); sw(d, 44, 32'h0001_0000 + 32'(3 - off));
      run(d, "R7 arith alignment");
      for (int dt = 0; dt < 10; dt++) begin
        d = base(1); sb(d, 32, 8'(dt)); sb(d, 33, 8'(dt));
        sw(d, 40, 32'h40 + 32'(off)); sw(d, 44, 32'h0002_0000 + 32'(off ^ 1));
        run(d, "R7 bitvec alignment");
      end
    end

    // R8: op sets, each op field
    for (int cls = 0; cls < 2; cls++)
      for (int op = 0; op < 64; op++) begin
        d = base(cls[0]); sb(d, 36, 8'(op)); sb(d, 37, 8'h00); run(d, "R8 op0 sweep");
        d = base(cls[0]); sb(d, 36, cls ? 8'h21 : 8'h02); sb(d, 37, 8'(op)); run(d, "R8 op1 sweep");
      end
    for (int cls = 0; cls < 2; cls++) begin
      d = base(cls[0]); sb(d, 36, 8'hFF); sb(d, 37, 8'h80); run(d, "R8 high op codes");
    end

    // R9: bypass first with non-bypass second
    for (int op = 0; op < 8; op++) begin
      d = base(0); sb(d, 36, 8'h00); sb(d, 37, 8'(op)); run(d, "R9 compose arith");
      d = base(1); sb(d, 36, 8'h00); sb(d, 37, 8'h20 + 8'(op)); run(d, "R9 compose bitvec");
    end

    // R10: dtype grid
    for (int cls = 0; cls < 2; cls++)
      for (int i = 0; i < 12; i++)
        for (int o = 0; o < 12; o++) begin
          d = base(cls[0]); sb(d, 32, 8'(i)); sb(d, 33, 8'(o));
          sw(d, 40, 32'h0); sw(d, 44, 32'h0);
          run(d, "R10 dtype grid");
        end

    // R11: operand-order code
    for (int r = 0; r < 8; r++) begin
      d = base(0); sb(d, 38, 8'(r)); run(d, "R11 operand order");
    end
    d = base(0); sb(d, 38, 8'hFF); run(d, "R11 operand order max");

    // R12: many faults stacked in one descriptor
    d = base(1);
    sb(d, 35, 1); sb(d, 13, 2); sb(d, 34, 8'd200); sw(d, 40, 32'hFFFF_0003); sw(d, 44, 32'h00FF_0001);
    sb(d, 36, 0); sb(d, 37, 8'h07); sb(d, 32, 8'd2); sb(d, 33, 8'd3); sb(d, 38, 8'd9);
    run(d, "R12 stacked faults");
    d = base(0); sb(d, 0, 8'h43); sb(d, 39, 4); sb(d, 12, 1); sb(d, 34, 0);
    sw(d, 40, 32'h2); sb(d, 36, 8'h1B); sb(d, 32, 8'd9); sb(d, 38, 8'd4);
    run(d, "R12 stacked faults arith");
    for (int k = 1; k < DESC_BYTES; k++) begin
      if (k == 12 || (k >= 32 && k <= 47) || k == 13 || k == 14 || k == 15) continue;
      d = base(0); sb(d, k, 8'h5A ^ 8'(k)); run(d, "R12 undecoded byte ignored");
    end

    check_idle("R1 final idle");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule